// File: doc/BRIEF.md
# Add/Subtract Immediate Execution Unit with Condition Flags

This unit performs one add or subtract per clock. One operand is a source register value. The other is a 12-bit unsigned immediate, which can be moved up by twelve bit positions before use. A size input picks 64-bit or 32-bit operation. One shared datapath serves both widths, and the four condition flags are derived at the selected width. The flags are negative, zero, carry and overflow.

The decoded fields arrive together with a valid strobe. One clock later the unit presents the result, a write enable and the destination index for the register file. When the flag-set input accompanied the operation, the flag outputs are updated in that same clock. Without it, the flags keep their earlier values. Subtraction is done as source plus inverted operand plus one, so carry means "no borrow".

Top module: `addsub_imm_alu`

## Requirements
- R1: With `op_sub`=0 the result is source + immediate; with `op_sub`=1 it is source − immediate, wrapped at the active width.
- R2: With `imm_shift`=1 the immediate is used as `imm12` × 4096; with `imm_shift`=0 it is used as `imm12` unchanged.
- R3: With `wide`=0 only the low 32 bits of the source take part, and bits 63..32 of `wr_data` are zero.
- R4: When flags are set, `flag_n` equals result bit 63 (`wide`=1) or bit 31 (`wide`=0), and `flag_z` is 1 exactly when the result at the active width is zero.
- R5: When flags are set, `flag_c` is the unsigned carry out of the active width for addition; for subtraction it is 1 when source ≥ immediate unsigned (no borrow).
- R6: When flags are set, `flag_v` signals signed overflow at the active width. For addition this means two operands of equal sign giving a result of the other sign. For subtraction it means operands of differing sign giving a result whose sign differs from the source.
- R7: The flags change only in the cycle after an accepted operation with `set_flags`=1. Otherwise they hold their value.
- R8: `wr_en` is 1 exactly one cycle after `in_valid`=1, and `wr_idx` then carries the `dst_idx` of that operation.
- R9: While `rst_n` is low, `wr_en` and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op_sub | input | 1 | 0 add, 1 subtract |
| set_flags | input | 1 | Update condition flags |
| wide | input | 1 | 1 selects 64-bit, 0 selects 32-bit |
| imm_shift | input | 1 | Shift immediate left by 12 |
| imm12 | input | 12 | Unsigned immediate |
| src_val | input | 64 | Source register value |
| dst_idx | input | 5 | Destination register index |
| wr_en | output | 1 | Result write enable |
| wr_idx | output | 5 | Destination index of the result |
| wr_data | output | 64 | Result value |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / not-borrow flag |
| flag_v | output | 1 | Signed overflow flag |

## Verification
The hardest case to reach is a 32-bit operation whose source has non-zero upper bits and sits at a signed or unsigned boundary of the low word. If the carry or overflow were taken from the 64-bit sum, or the upper bits were not cleared, only that case would show it. The stimulus sweeps a grid of boundary sources: zero, all ones, and the signed minimum and maximum at each width, each with junk in the unused half. The grid covers both operations, both widths, both shift settings and immediates 0, 1 and 4095. Random operations and idle cycles with the flag-set input raised follow, all compared against a behavioural model every clock.

// File: rtl/addsub_alu_pkg.sv
package addsub_alu_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/imm_operand.sv
module imm_operand #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 12
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic              imm_shift,
  input  logic              op_sub,
  output logic [DATA_W-1:0] operand,
  output logic              carry_in
);
  logic [DATA_W-1:0] imm_ext;

  always_comb begin
    imm_ext = '0;
    if (imm_shift) imm_ext[2*IMM_W-1:IMM_W] = imm;
    else           imm_ext[IMM_W-1:0]       = imm;
    // subtraction: add the one's complement plus one
    operand  = op_sub ? ~imm_ext : imm_ext;
    carry_in = op_sub;
  end
endmodule

// File: rtl/lane_adder.sv
module lane_adder #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 32,
  localparam int NLANES = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic [NLANES-1:0] lane_cout
);
  logic [NLANES:0] chain;
  assign chain[0] = cin;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    logic [LANE_W:0] part;
    assign part = {1'b0, a[g*LANE_W +: LANE_W]} + {1'b0, b[g*LANE_W +: LANE_W]}
                  + {{LANE_W{1'b0}}, chain[g]};
    assign sum[g*LANE_W +: LANE_W] = part[LANE_W-1:0];
    assign chain[g+1]   = part[LANE_W];
    assign lane_cout[g] = part[LANE_W];
  end
endmodule

// File: rtl/flag_unit.sv
module flag_unit
  import addsub_alu_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  localparam int NLANES  = DATA_W / NARROW_W
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] sum,
  input  logic [NLANES-1:0] lane_cout,
  input  logic              wide,
  output logic [DATA_W-1:0] result,
  output nzcv_t             flags
);
  logic a_msb, b_msb, r_msb;

  always_comb begin
    result = wide ? sum : {{(DATA_W-NARROW_W){1'b0}}, sum[NARROW_W-1:0]};
    a_msb  = wide ? a[DATA_W-1]   : a[NARROW_W-1];
    b_msb  = wide ? b[DATA_W-1]   : b[NARROW_W-1];
    r_msb  = wide ? sum[DATA_W-1] : sum[NARROW_W-1];
    flags.n = r_msb;
    flags.z = (result == '0);
    flags.c = wide ? lane_cout[NLANES-1] : lane_cout[0];
    flags.v = (a_msb == b_msb) && (r_msb != a_msb);
  end
endmodule

// File: rtl/addsub_imm_alu.sv
module addsub_imm_alu
  import addsub_alu_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int IMM_W    = 12,
  parameter int IDX_W    = 5,
  localparam int NLANES  = DATA_W / NARROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              op_sub,
  input  logic              set_flags,
  input  logic              wide,
  input  logic              imm_shift,
  input  logic [IMM_W-1:0]  imm12,
  input  logic [DATA_W-1:0] src_val,
  input  logic [IDX_W-1:0]  dst_idx,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v
);
  logic [DATA_W-1:0] operand_b, sum, result;
  logic              cin;
  logic [NLANES-1:0] lane_cout;
  nzcv_t             new_flags;

  nzcv_t             flags_q, flags_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              wen_q;
  logic              flag_upd;

  imm_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .imm(imm12), .imm_shift(imm_shift), .op_sub(op_sub),
    .operand(operand_b), .carry_in(cin)
  );

  lane_adder #(.DATA_W(DATA_W), .LANE_W(NARROW_W)) u_add (
    .a(src_val), .b(operand_b), .cin(cin), .sum(sum), .lane_cout(lane_cout)
  );

  flag_unit #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_flags (
    .a(src_val), .b(operand_b), .sum(sum), .lane_cout(lane_cout),
    .wide(wide), .result(result), .flags(new_flags)
  );

  always_comb begin
    flag_upd = in_valid && set_flags;
    flags_d  = flag_upd ? new_flags : flags_q;
    data_d   = in_valid ? result    : data_q;
    idx_d    = in_valid ? dst_idx   : idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      data_q  <= '0;
      idx_q   <= '0;
      wen_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      data_q  <= data_d;
      idx_q   <= idx_d;
      wen_q   <= in_valid;
    end
  end

  assign wr_en   = wen_q;
  assign wr_idx  = idx_q;
  assign wr_data = data_q;
  assign flag_n  = flags_q.n;
  assign flag_z  = flags_q.z;
  assign flag_c  = flags_q.c;
  assign flag_v  = flags_q.v;
endmodule

// File: rtl/addsub_alu_checker.sv
module addsub_alu_checker #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 12,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              op_sub,
  input logic              set_flags,
  input logic              wide,
  input logic              imm_shift,
  input logic [IMM_W-1:0]  imm12,
  input logic [DATA_W-1:0] src_val,
  input logic [IDX_W-1:0]  dst_idx,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_c,
  input logic              flag_v
);
  p_wren_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> wr_en);
  p_wren_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !wr_en);
  p_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (wr_idx == $past(dst_idx)));
  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide) |=> (wr_data[DATA_W-1:32] == '0));
  p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && set_flags) |=> (flag_z == (wr_data == '0)));
  p_neg_wide_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && set_flags && wide) |=> (flag_n == wr_data[DATA_W-1]));
  p_neg_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && set_flags && !wide) |=> (flag_n == wr_data[31]));
  p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && set_flags) |=> $stable({flag_n, flag_z, flag_c, flag_v}));
  p_add_zero_imm_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && wide && imm12 == '0) |=> (wr_data == $past(src_val)));
endmodule

bind addsub_imm_alu addsub_alu_checker i_chk (.*);

// File: tb/test_addsub_imm_alu.sv
module test_addsub_imm_alu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, op_sub, set_flags, wide, imm_shift;
  logic [11:0] imm12;
  logic [63:0] src_val;
  logic [4:0]  dst_idx;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [63:0] wr_data;
  logic        flag_n, flag_z, flag_c, flag_v;

  int n_checks = 0;
  int n_fail   = 0;

  logic [3:0]  exp_flags;
  logic        exp_wen;
  logic [4:0]  exp_idx;
  logic [63:0] exp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  addsub_imm_alu i_addsub_imm_alu (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void model(input bit sub, input bit sf, input bit sh,
                                input logic [11:0] imm, input logic [63:0] src,
                                output logic [63:0] res, output logic [3:0] f);
    logic [63:0] b;
    logic [32:0] s33;
    logic [64:0] s65;
    logic [31:0] r32;
    bit c, sa, sb, sr, v;
    b = sh ? {40'd0, imm, 12'd0} : {52'd0, imm};
    if (sf) begin
      if (sub) begin res = src - b; c = (src >= b); end
      else begin s65 = {1'b0, src} + {1'b0, b}; res = s65[63:0]; c = s65[64]; end
      sa = src[63]; sb = b[63]; sr = res[63];
    end else begin
      if (sub) begin r32 = src[31:0] - b[31:0]; c = (src[31:0] >= b[31:0]); end
      else begin s33 = {1'b0, src[31:0]} + {1'b0, b[31:0]}; r32 = s33[31:0]; c = s33[32]; end
      res = {32'd0, r32};
      sa = src[31]; sb = b[31]; sr = r32[31];
    end
    v = sub ? (sa != sb && sr != sa) : (sa == sb && sr != sa);
    f = {sr, (res == 64'd0), c, v};
  endfunction

  task automatic op(input bit vld, input bit sub, input bit sf, input bit sh, input bit setf,
                    input logic [11:0] imm, input logic [63:0] src, input logic [4:0] idx);
    logic [63:0] r;
    logic [3:0]  f;
    string dtag;
    in_valid = vld; op_sub = sub; wide = sf; imm_shift = sh; set_flags = setf;
    imm12 = imm; src_val = src; dst_idx = idx;
    model(sub, sf, sh, imm, src, r, f);
    @(posedge clk);
    exp_wen = vld;
    if (vld) begin exp_data = r; exp_idx = idx; end
    if (vld && setf) exp_flags = f;
    @(negedge clk);
    dtag = !sf ? "R3 data" : (sh ? "R2 data" : "R1 data");
    check("R8 wr_en", {63'd0, wr_en}, {63'd0, exp_wen});
    if (vld) begin
      check("R8 wr_idx", {59'd0, wr_idx}, {59'd0, exp_idx});
      check(dtag, wr_data, exp_data);
    end
    if (vld && setf) begin
      check("R4 N", {63'd0, flag_n}, {63'd0, exp_flags[3]});
      check("R4 Z", {63'd0, flag_z}, {63'd0, exp_flags[2]});
      check("R5 C", {63'd0, flag_c}, {63'd0, exp_flags[1]});
      check("R6 V", {63'd0, flag_v}, {63'd0, exp_flags[0]});
    end else begin
      check("R7 flags held", {60'd0, flag_n, flag_z, flag_c, flag_v}, {60'd0, exp_flags});
    end
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] srcs [8];
    logic [11:0] imms [3];
    srcs = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
             64'hABCD_0000_7FFF_FFFF, 64'h1234_5678_8000_0000, 64'h0000_0001_0000_0000,
             64'h0000_0000_0000_0FFF};
    imms = '{12'h000, 12'h001, 12'hFFF};
    rst_n = 1'b0; in_valid = 0; op_sub = 0; set_flags = 0; wide = 0; imm_shift = 0;
    imm12 = '0; src_val = '0; dst_idx = '0;
    exp_flags = 4'd0; exp_wen = 0; exp_idx = '0; exp_data = '0;
    repeat (2) @(negedge clk);
    check("R9 wr_en reset", {63'd0, wr_en}, 64'd0);
    check("R9 flags reset", {60'd0, flag_n, flag_z, flag_c, flag_v}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // boundary grid: R1 R2 R3 R4 R5 R6
    for (int s = 0; s < 8; s++)
      for (int i = 0; i < 3; i++)
        for (int m = 0; m < 8; m++)
          op(1, m[0], m[1], m[2], 1, imms[i], srcs[s], 5'(s + i + m));
    // exact zero results in both widths
    op(1, 1, 1, 0, 1, 12'h5, 64'h5, 5'd1);
    op(1, 1, 0, 1, 1, 12'h1, 64'hFFFF_0000_0000_1000, 5'd2);
    // R7: idle with set_flags high, and valid without set_flags
    op(0, 1, 1, 0, 1, 12'hFFF, 64'h0, 5'd3);
    op(1, 1, 1, 0, 0, 12'h001, 64'h0, 5'd4);
    op(0, 0, 0, 0, 1, 12'h000, 64'h0, 5'd5);
    // random mix
    for (int k = 0; k < 400; k++)
      op(($urandom % 5) != 0, $urandom, $urandom, $urandom, $urandom,
         12'($urandom), {$urandom, $urandom}, 5'($urandom));
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule